// File: doc/BRIEF.md
# Command Byte Decoder with Per-Channel Calibration Registers

This block sits behind the serial port of a multi-channel converter. It interprets each 8-bit command byte, separates conversion requests from calibration requests and sends single-cycle start strobes to the conversion and calibration engines. It also keeps one offset word and one gain word for each physical input channel. A lookup table maps each setup (a numbered configuration slot) to a physical channel. When the calibration engine reports completion, its result goes into the register of the channel that the requesting setup maps to.

A command has bit 7 set. Bits 6..3 form a setup pointer, where setup number = pointer + 1. Bits 2..0 form a calibration code, and code 000 asks for a conversion. In single-setup mode the pointer picks the setup to convert. In multi-setup mode the pointer is ignored and the sequence starts from the first setup. While a calibration runs, the block stays in command mode. It drops any byte that arrives, and it lowers an active-low done flag when the calibration completes. The calibration arithmetic lives outside this block.

Top module: `cmd_cal_decoder`

## Requirements
- R1: A byte with bit 7 = 0 produces no start strobe, leaves `sdo_n` unchanged and leaves every calibration register unchanged.
- R2: A byte with bit 7 = 1 and bits 2..0 = 000, accepted while no calibration is running, raises `conv_start` for exactly one cycle, starting on the cycle after `cmd_valid`.
- R3: With `multi_mode` = 0, `conv_setup` equals bits 6..3 of the accepted byte (setup number minus one), and `conv_multi` is 0.
- R4: With `multi_mode` = 1, the pointer field is ignored: `conv_setup` is 0 and `conv_multi` is 1.
- R5: Codes 001, 010, 101 and 110 raise `cal_start` for one cycle on the cycle after `cmd_valid`, with `cal_kind` = 0 (self offset), 1 (self gain), 2 (system offset) and 3 (system gain) respectively. `cal_setup` carries bits 6..3, and `cal_chan` carries the table entry `setup_map[3*p +: 3]` for pointer p. `cal_busy` rises at the same time.
- R6: Codes 011, 100 and 111 start nothing and change no state.
- R7: While `cal_busy` is 1, every byte is discarded (no strobe, no state change), and each calibration command runs exactly one calibration.
- R8: `eng_done` during a calibration writes `eng_result` to the offset register (kinds 0 and 2) or the gain register (kinds 1 and 3) of `cal_chan`, and to no other register. On the next cycle `cal_busy` is 0, `sdo_n` is 0 and the read port shows the new value.
- R9: Calibration storage is per physical channel: a later calibration through a different setup that maps to the same channel overwrites the earlier result.
- R10: After reset every offset register reads 0, every gain register reads 0x400000, `sdo_n` is 1 and `cal_busy` and both strobes are 0.
- R11: `sdo_n` returns to 1 on the cycle after any accepted command. `eng_done` while no calibration is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Received command byte |
| multi_mode | input | 1 | 1 = multi-setup sequence, 0 = single setup from pointer |
| setup_map | input | NUM_SETUPS*CH_W (48) | Physical channel of each setup, setup s at bits [s*CH_W +: CH_W] |
| eng_done | input | 1 | Calibration engine completion pulse |
| eng_result | input | DATA_W (24) | Calibration result word |
| rd_chan | input | CH_W (3) | Channel selected on the read ports |
| conv_start | output | 1 | Conversion start strobe |
| conv_multi | output | 1 | Conversion runs the multi-setup sequence |
| conv_setup | output | 4 | Setup index for the conversion |
| cal_start | output | 1 | Calibration start strobe |
| cal_kind | output | 2 | Calibration kind |
| cal_setup | output | 4 | Setup index being calibrated |
| cal_chan | output | CH_W (3) | Physical channel being calibrated |
| cal_busy | output | 1 | Calibration in progress |
| sdo_n | output | 1 | Active-low done flag |
| rd_offset | output | DATA_W (24) | Offset register of `rd_chan` |
| rd_gain | output | DATA_W (24) | Gain register of `rd_chan` |

## Verification
A stale busy flag shows up on the very next byte. Either a command after completion is lost (no strobe one cycle after `cmd_valid`), or a byte sent mid-calibration produces a second strobe. A wrongly latched channel or kind is invisible until completion. After that, one cycle later, the read ports show the result in the wrong channel or in the wrong register of the pair. For this reason the bench compares every channel's read ports with its model, not only the channel being calibrated. A wrong pointer or table lookup appears on `conv_setup` or `cal_chan` in the strobe cycle.

// File: rtl/cmd_cal_pkg.sv
package cmd_cal_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 4;
  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    KIND_SELF_OFS  = 2'd0,
    KIND_SELF_GAIN = 2'd1,
    KIND_SYS_OFS   = 2'd2,
    KIND_SYS_GAIN  = 2'd3
  } cal_kind_e;

  typedef struct packed {
    logic              is_cmd;
    logic              is_conv;
    logic              is_cal;
    logic [PTR_W-1:0]  ptr;
    logic [CODE_W-1:0] code;
  } cmd_fields_t;

  // Only four calibration codes are meaningful; others are dropped.
  function automatic logic code_is_cal(input logic [CODE_W-1:0] c);
    case (c)
      3'b001, 3'b010, 3'b101, 3'b110: return 1'b1;
      default:                        return 1'b0;
    endcase
  endfunction

  function automatic cal_kind_e code_to_kind(input logic [CODE_W-1:0] c);
    case (c)
      3'b010:  return KIND_SELF_GAIN;
      3'b101:  return KIND_SYS_OFS;
      3'b110:  return KIND_SYS_GAIN;
      default: return KIND_SELF_OFS;
    endcase
  endfunction

  function automatic logic kind_is_gain(input cal_kind_e k);
    return (k == KIND_SELF_GAIN) || (k == KIND_SYS_GAIN);
  endfunction
endpackage

// File: rtl/cmd_field_decode.sv
module cmd_field_decode
  import cmd_cal_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd_byte,
  output cmd_fields_t       fields
);
  localparam int MSB      = BYTE_W - 1;
  localparam int PTR_LO   = CODE_W;
  localparam int PTR_HI   = CODE_W + PTR_W - 1;

  always_comb begin
    fields.is_cmd  = cmd_byte[MSB];
    fields.ptr     = cmd_byte[PTR_HI:PTR_LO];
    fields.code    = cmd_byte[CODE_W-1:0];
    fields.is_conv = cmd_byte[MSB] && (cmd_byte[CODE_W-1:0] == '0);
    fields.is_cal  = cmd_byte[MSB] && code_is_cal(cmd_byte[CODE_W-1:0]);
  end
endmodule

// File: rtl/cal_seq.sv
module cal_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic any_accept,
  input  logic cal_accept,
  input  logic eng_done,
  output logic busy,
  output logic sdo_n,
  output logic finish
);
  assign finish = busy && eng_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      sdo_n <= 1'b1;
    end else if (finish) begin
      busy  <= 1'b0;
      sdo_n <= 1'b0;
    end else if (any_accept) begin
      busy  <= cal_accept;
      sdo_n <= 1'b1;
    end
  end
endmodule

// File: rtl/chan_cal_bank.sv
module chan_cal_bank #(
  parameter int          NUM_CHANS  = 8,
  parameter int          DATA_W     = 24,
  parameter int unsigned GAIN_RESET = 32'h0040_0000,
  localparam int         CH_W       = $clog2(NUM_CHANS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic              wr_gain,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CH_W-1:0]   rd_chan,
  output logic [DATA_W-1:0] rd_offset,
  output logic [DATA_W-1:0] rd_gain
);
  localparam logic [DATA_W-1:0] GAIN_INIT = DATA_W'(GAIN_RESET);

  logic [DATA_W-1:0] ofs_view  [NUM_CHANS];
  logic [DATA_W-1:0] gain_view [NUM_CHANS];

  for (genvar g = 0; g < NUM_CHANS; g++) begin : g_chan
    logic              hit;
    logic [DATA_W-1:0] ofs_q;
    logic [DATA_W-1:0] gain_q;

    assign hit = wr_en && (wr_chan == CH_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ofs_q  <= '0;
        gain_q <= GAIN_INIT;
      end else if (hit) begin
        if (wr_gain) gain_q <= wr_data;
        else         ofs_q  <= wr_data;
      end
    end

    assign ofs_view[g]  = ofs_q;
    assign gain_view[g] = gain_q;
  end

  assign rd_offset = ofs_view[rd_chan];
  assign rd_gain   = gain_view[rd_chan];
endmodule

// File: rtl/cmd_cal_decoder.sv
module cmd_cal_decoder
  import cmd_cal_pkg::*;
#(
  parameter int          NUM_SETUPS = 16,
  parameter int          NUM_CHANS  = 8,
  parameter int          DATA_W     = 24,
  parameter int unsigned GAIN_RESET = 32'h0040_0000,
  localparam int         CH_W       = $clog2(NUM_CHANS),
  localparam int         MAP_W      = NUM_SETUPS * CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_byte,
  input  logic              multi_mode,
  input  logic [MAP_W-1:0]  setup_map,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] eng_result,
  input  logic [CH_W-1:0]   rd_chan,
  output logic              conv_start,
  output logic              conv_multi,
  output logic [3:0]        conv_setup,
  output logic              cal_start,
  output logic [1:0]        cal_kind,
  output logic [3:0]        cal_setup,
  output logic [CH_W-1:0]   cal_chan,
  output logic              cal_busy,
  output logic              sdo_n,
  output logic [DATA_W-1:0] rd_offset,
  output logic [DATA_W-1:0] rd_gain
);
  cmd_fields_t     fields;
  logic            conv_accept;
  logic            cal_accept;
  logic            cmd_accept;
  logic            cmd_drop;
  logic            cal_finish;
  logic [CH_W-1:0] ptr_chan;
  cal_kind_e       kind_d;
  cal_kind_e       kind_q;

  cmd_field_decode u_decode (
    .cmd_byte (cmd_byte),
    .fields   (fields)
  );

  assign conv_accept = cmd_valid && !cal_busy && fields.is_conv;
  assign cal_accept  = cmd_valid && !cal_busy && fields.is_cal;
  assign cmd_accept  = conv_accept || cal_accept;
  assign cmd_drop    = cmd_valid && cal_busy;
  assign ptr_chan    = setup_map[int'(fields.ptr)*CH_W +: CH_W];
  assign kind_d      = code_to_kind(fields.code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_start <= 1'b0;
      conv_multi <= 1'b0;
      conv_setup <= '0;
      cal_start  <= 1'b0;
      cal_setup  <= '0;
      cal_chan   <= '0;
      kind_q     <= KIND_SELF_OFS;
    end else begin
      conv_start <= conv_accept;
      cal_start  <= cal_accept;
      if (conv_accept) begin
        conv_multi <= multi_mode;
        conv_setup <= multi_mode ? '0 : fields.ptr;
      end
      if (cal_accept) begin
        cal_setup <= fields.ptr;
        cal_chan  <= ptr_chan;
        kind_q    <= kind_d;
      end
    end
  end

  assign cal_kind = kind_q;

  cal_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_accept (cmd_accept),
    .cal_accept (cal_accept),
    .eng_done   (eng_done),
    .busy       (cal_busy),
    .sdo_n      (sdo_n),
    .finish     (cal_finish)
  );

  chan_cal_bank #(
    .NUM_CHANS  (NUM_CHANS),
    .DATA_W     (DATA_W),
    .GAIN_RESET (GAIN_RESET)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cal_finish),
    .wr_chan   (cal_chan),
    .wr_gain   (kind_is_gain(kind_q)),
    .wr_data   (eng_result),
    .rd_chan   (rd_chan),
    .rd_offset (rd_offset),
    .rd_gain   (rd_gain)
  );
endmodule

// File: rtl/cmd_cal_decoder_sva.sv
module cmd_cal_decoder_sva #(
  parameter int CH_W   = 3,
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [7:0]        cmd_byte,
  input logic              eng_done,
  input logic              cal_busy,
  input logic              cal_start,
  input logic              conv_start,
  input logic              conv_multi,
  input logic [3:0]        conv_setup,
  input logic              sdo_n,
  input logic [CH_W-1:0]   rd_chan,
  input logic [DATA_W-1:0] rd_offset,
  input logic [DATA_W-1:0] rd_gain,
  input logic              cmd_drop,
  input logic              cal_finish
);
  a_r1_plain_byte_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_byte[7]) |=> (!conv_start && !cal_start));

  a_r2_one_strobe_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_start && cal_start));

  a_r4_multi_from_first: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && conv_multi) |-> (conv_setup == 4'd0));

  a_r5_start_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> cal_busy);

  a_r7_drop_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_drop |=> (!conv_start && !cal_start));

  a_r8_finish_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && eng_done) |=> (!cal_busy && !sdo_n));

  a_r8_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_finish |=> (!$stable(rd_chan) || ($stable(rd_offset) && $stable(rd_gain))));

  a_r11_idle_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_busy && eng_done && !cmd_valid) |=> ($stable(sdo_n) && !cal_busy));
endmodule

bind cmd_cal_decoder cmd_cal_decoder_sva #(.CH_W(CH_W), .DATA_W(DATA_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_byte   (cmd_byte),
  .eng_done   (eng_done),
  .cal_busy   (cal_busy),
  .cal_start  (cal_start),
  .conv_start (conv_start),
  .conv_multi (conv_multi),
  .conv_setup (conv_setup),
  .sdo_n      (sdo_n),
  .rd_chan    (rd_chan),
  .rd_offset  (rd_offset),
  .rd_gain    (rd_gain),
  .cmd_drop   (cmd_drop),
  .cal_finish (cal_finish)
);

// File: tb/cmd_cal_decoder_tb.sv
`timescale 1ns/1ps
module cmd_cal_decoder_tb;
  localparam int NS = 16;
  localparam int NC = 8;
  localparam int CW = 3;
  localparam int DW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic multi_mode = 1'b0;
  logic [NS*CW-1:0] setup_map;
  logic eng_done = 1'b0;
  logic [DW-1:0] eng_result = '0;
  logic [CW-1:0] rd_chan = '0;
  logic conv_start, conv_multi, cal_start, cal_busy, sdo_n;
  logic [3:0] conv_setup, cal_setup;
  logic [1:0] cal_kind;
  logic [CW-1:0] cal_chan;
  logic [DW-1:0] rd_offset, rd_gain;

  always #2.5 clk = ~clk;

  cmd_cal_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .multi_mode(multi_mode), .setup_map(setup_map), .eng_done(eng_done),
    .eng_result(eng_result), .rd_chan(rd_chan), .conv_start(conv_start),
    .conv_multi(conv_multi), .conv_setup(conv_setup), .cal_start(cal_start),
    .cal_kind(cal_kind), .cal_setup(cal_setup), .cal_chan(cal_chan),
    .cal_busy(cal_busy), .sdo_n(sdo_n), .rd_offset(rd_offset), .rd_gain(rd_gain)
  );

  // Channel order used by the table: setup s -> entry below.
  int chan_order [NS] = '{5, 0, 5, 1, 5, 2, 5, 3, 5, 4, 5, 1, 5, 6, 5, 7};
  initial begin
    for (int s = 0; s < NS; s++) setup_map[s*CW +: CW] = CW'(chan_order[s]);
  end

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [DW-1:0] m_ofs  [NC];
  logic [DW-1:0] m_gain [NC];
  bit m_busy, m_sdo, m_conv_start, m_conv_multi, m_cal_start, m_is_gain;
  int m_conv_setup, m_cal_setup, m_cal_chan, m_cal_kind;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin m_ofs[c] <= '0; m_gain[c] <= 24'h400000; end
      m_busy <= 0; m_sdo <= 1; m_conv_start <= 0; m_cal_start <= 0;
    end else begin
      m_conv_start <= 0;
      m_cal_start  <= 0;
      if (m_busy && eng_done) begin
        if (m_is_gain) m_gain[m_cal_chan] <= eng_result;
        else           m_ofs[m_cal_chan]  <= eng_result;
        m_busy <= 0;
        m_sdo  <= 0;
      end else if (!m_busy && cmd_valid && cmd_byte[7]) begin
        int ptr, code, kind;
        ptr  = int'(cmd_byte[6:3]);
        code = int'(cmd_byte[2:0]);
        kind = -1;
        case (code)
          1: kind = 0;
          2: kind = 1;
          5: kind = 2;
          6: kind = 3;
          default: kind = -1;
        endcase
        if (code == 0) begin
          m_conv_start <= 1;
          m_conv_multi <= multi_mode;
          m_conv_setup <= multi_mode ? 0 : ptr;
          m_sdo <= 1;
        end else if (kind >= 0) begin
          m_cal_start <= 1;
          m_cal_kind  <= kind;
          m_cal_setup <= ptr;
          m_cal_chan  <= chan_order[ptr];
          m_is_gain   <= (kind == 1) || (kind == 3);
          m_busy <= 1;
          m_sdo  <= 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk("R2", "conv_start", 32'(conv_start), 32'(m_conv_start));
      if (m_conv_start) begin
        chk("R3", "conv_setup", 32'(conv_setup), 32'(m_conv_setup));
        chk("R4", "conv_multi", 32'(conv_multi), 32'(m_conv_multi));
      end
      chk("R5", "cal_start", 32'(cal_start), 32'(m_cal_start));
      if (m_cal_start) begin
        chk("R5", "cal_kind", 32'(cal_kind), 32'(m_cal_kind));
        chk("R5", "cal_setup", 32'(cal_setup), 32'(m_cal_setup));
        chk("R5", "cal_chan", 32'(cal_chan), 32'(m_cal_chan));
      end
      chk("R7", "cal_busy", 32'(cal_busy), 32'(m_busy));
      chk("R11", "sdo_n", 32'(sdo_n), 32'(m_sdo));
      chk("R8", "rd_offset", 32'(rd_offset), 32'(m_ofs[rd_chan]));
      chk("R8", "rd_gain", 32'(rd_gain), 32'(m_gain[rd_chan]));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send_cmd(input logic [7:0] b);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_byte = b;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic finish_cal(input logic [DW-1:0] r);
    @(posedge clk); #1;
    eng_done = 1'b1; eng_result = r;
    @(posedge clk); #1;
    eng_done = 1'b0;
  endtask

  task automatic scan_regs(input string req);
    for (int c = 0; c < NC; c++) begin
      rd_chan = CW'(c);
      @(negedge clk);
      chk(req, "scan offset", 32'(rd_offset), 32'(m_ofs[c]));
      chk(req, "scan gain", 32'(rd_gain), 32'(m_gain[c]));
    end
  endtask

  task automatic summary();
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin : main
    logic sdo_before;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10: reset values on every channel and on the flags
    @(negedge clk);
    chk("R10", "sdo_n after reset", 32'(sdo_n), 32'd1);
    chk("R10", "cal_busy after reset", 32'(cal_busy), 32'd0);
    chk("R10", "strobes after reset", 32'({conv_start, cal_start}), 32'd0);
    for (int c = 0; c < NC; c++) begin
      rd_chan = CW'(c);
      @(negedge clk);
      chk("R10", "offset reset", 32'(rd_offset), 32'd0);
      chk("R10", "gain reset", 32'(rd_gain), 32'h400000);
    end

    // R1: byte with MSB clear
    sdo_before = sdo_n;
    send_cmd(8'h2D);
    @(negedge clk);
    chk("R1", "no strobe", 32'({conv_start, cal_start}), 32'd0);
    chk("R1", "sdo_n kept", 32'(sdo_n), 32'(sdo_before));

    // R2/R3: single-setup conversion of the 15th setup
    multi_mode = 1'b0;
    send_cmd(8'hF0);
    @(negedge clk);
    chk("R3", "pointer 1110", 32'(conv_setup), 32'd14);
    @(negedge clk);
    chk("R2", "one-cycle pulse", 32'(conv_start), 32'd0);

    // R4: multi-setup, pointer ignored
    multi_mode = 1'b1;
    send_cmd(8'h98);
    @(negedge clk);
    chk("R4", "multi setup 0", 32'({conv_multi, conv_setup}), 32'h10);
    multi_mode = 1'b0;

    // R5: system offset calibration on setup 6 (pointer 5 -> channel 2)
    send_cmd(8'hAD);
    @(negedge clk);
    chk("R5", "sys offset kind", 32'(cal_kind), 32'd2);
    chk("R5", "channel lookup", 32'(cal_chan), 32'd2);

    // R7: byte sent mid-calibration is dropped
    send_cmd(8'hF0);
    @(negedge clk);
    chk("R7", "dropped byte", 32'({conv_start, cal_start}), 32'd0);
    chk("R7", "still busy", 32'(cal_busy), 32'd1);

    // R8: completion writes channel 2 offset
    rd_chan = 3'd2;
    finish_cal(24'h123456);
    @(negedge clk);
    chk("R8", "offset written", 32'(rd_offset), 32'h123456);
    chk("R8", "sdo_n low", 32'(sdo_n), 32'd0);
    scan_regs("R8");

    // R11: idle completion pulse ignored
    finish_cal(24'hFFFFFF);
    @(negedge clk);
    chk("R11", "idle done ignored", 32'({cal_busy, sdo_n}), 32'd0);
    scan_regs("R11");

    // R6: reserved codes
    send_cmd(8'h83);
    send_cmd(8'h84);
    send_cmd(8'h87);
    @(negedge clk);
    chk("R6", "reserved codes", 32'({cal_busy, sdo_n, cal_start}), 32'd0);

    // R9: two gain calibrations through setups 4 and 12, both channel 1
    send_cmd(8'h9A);
    finish_cal(24'h3ABCDE);
    send_cmd(8'hDE);
    @(negedge clk);
    chk("R9", "second setup same chan", 32'(cal_chan), 32'd1);
    rd_chan = 3'd1;
    finish_cal(24'h410000);
    @(negedge clk);
    chk("R9", "gain overwritten", 32'(rd_gain), 32'h410000);

    // R11: accepted command raises sdo_n again
    send_cmd(8'h81);
    @(negedge clk);
    chk("R11", "sdo_n raised", 32'(sdo_n), 32'd1);
    finish_cal(24'h00ABCD);
    scan_regs("R8");

    // Mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #1;
      cmd_valid  = ($urandom % 3) == 0;
      cmd_byte   = 8'($urandom);
      multi_mode = 1'($urandom);
      eng_done   = ($urandom % 4) == 0;
      eng_result = 24'($urandom);
      rd_chan    = CW'($urandom);
    end
    @(posedge clk); #1;
    cmd_valid = 1'b0; eng_done = 1'b0;
    scan_regs("R9");

    summary();
  end
endmodule